// File: doc/BRIEF.md
# Master Link Polling Controller

This block is the master-side sequencer for a half-duplex, master/slave link that carries two slave units (slot A and slot B) on one shared wire pair. It chooses which slave to address next and builds the control byte for that turn. It then waits a bounded time for the slave's answer. The answer arrives as a decoded control byte from the line receiver. The line coding, the framing of data bytes and the packet payload belong to neighbouring blocks.

After reset, each slave is brought into step with a link-reset handshake. Synced slaves are then polled in turn. When the host has a packet waiting for a slave, that slave is asked for its buffer state instead of being polled, and the packet is released only if the slave reports free space. Each released packet gets a running sequence number, so the far end can spot a lost packet. A slave may ask to reboot only as the answer to a data poll; the master then drops it back into the link-reset handshake. A slave that stays silent for a set number of turns is marked absent. From then on the other slave gets nearly all the turns, and the absent one is probed now and then so it can come back.

Top module: `link_poll_master`

## Requirements
- R1: Each control byte has the slave address in bits [1:0] (slot A = 01, slot B = 10) and the command in bits [5:2]. Bit 6 makes the number of ones in bits [6:0] odd, and bit 7 is 0. Command codes: IDLE=0, POLL=1, DATA=2, REBOOT=3, LINKRST=4, BUFQ=5, BUF_NO=6, BUF_OK=7.
- R2: During and after reset, slave_up and slave_absent are 0 and no strobe or grant is issued. A slave that is not synced is sent LINKRST on each of its turns, and slave_up for that slot is set the cycle after it answers IDLE.
- R3: When both slaves are present, or both are absent, successive commands alternate between slot A and slot B, starting with A.
- R4: A synced slave with no pending host data is sent POLL. When data_pend for that slot is high, the slave is sent BUFQ instead.
- R5: A BUF_OK answer to BUFQ raises data_go for one cycle, with data_dst naming the slot and data_seq carrying the sequence number. The sequence number starts at 0 and goes up by one for each grant.
- R6: A BUF_NO answer produces no grant. The pending data is held, and the slave is asked with BUFQ again on its next turn.
- R7: A REBOOT answer to POLL clears slave_up for that slot. The next command to that slot is LINKRST.
- R8: A REBOOT answer to any command other than POLL is ignored, and slave_up stays set.
- R9: An answer with bad parity, bit 7 set, or another slot's address counts as a missed answer. It does not change the slot's sync state.
- R10: No answer within TIMEOUT cycles of the strobe counts as a miss. After MISS_LIMIT consecutive misses the slot is marked absent and its slave_up is cleared. A valid answer resets the miss count.
- R11: While exactly one slot is absent, PROBE_GAP commands go to the present slot between successive probes of the absent slot, and each probe is LINKRST.
- R12: A valid answer to a probe clears slave_absent for that slot. An IDLE answer to the probe also sets slave_up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_pend | input | 2 | Host has a packet waiting for slot A (bit 0) / slot B (bit 1) |
| rx_valid | input | 1 | A decoded control byte from the receiver is present |
| rx_byte | input | 8 | Decoded control byte |
| tx_strobe | output | 1 | One-cycle request to send tx_byte on the line |
| tx_byte | output | 8 | Control byte to send |
| data_go | output | 1 | One-cycle grant to send the pending packet |
| data_dst | output | 1 | Slot for the granted packet (0 = A, 1 = B) |
| data_seq | output | SEQ_W | Sequence number for the granted packet |
| slave_up | output | 2 | Slot is synced and taking part in polling |
| slave_absent | output | 2 | Slot has been declared absent |

## Verification
The hardest states to reach from the ports are the ones that depend on the history of answers: an absent slot that is later probed and recovers, and a reboot request that arrives as the answer to a buffer query. The bench drives both slots with a reactive slave model. The model decodes every strobed byte and answers according to per-slot switches that the test flips between phases: present, buffer free, reboot on next poll, reboot on next buffer query, and corrupt the next answer. Silencing slot B and then counting the slot of each later command shows the absence threshold and the probe spacing directly at the ports.

// File: rtl/link_poll_master.sv
module link_poll_master #(
  parameter int TIMEOUT    = 64,
  parameter int MISS_LIMIT = 4,
  parameter int PROBE_GAP  = 8,
  parameter int SEQ_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       data_pend,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             tx_strobe,
  output logic [7:0]       tx_byte,
  output logic             data_go,
  output logic             data_dst,
  output logic [SEQ_W-1:0] data_seq,
  output logic [1:0]       slave_up,
  output logic [1:0]       slave_absent
);
  localparam int TW = $clog2(TIMEOUT);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int PW = $clog2(PROBE_GAP + 1);

  localparam logic [3:0] C_IDLE = 4'd0, C_POLL = 4'd1, C_REBOOT = 4'd3, C_LINKRST = 4'd4,
                         C_BUFQ = 4'd5, C_BUF_OK = 4'd7;

  typedef enum logic [1:0] {S_PICK, S_SEND, S_WAIT} st_t;

  st_t              st;
  logic             sel, last;
  logic [3:0]       cmd_q;
  logic [TW-1:0]    tmr;
  logic [MW-1:0]    miss [2];
  logic [PW-1:0]    skip;
  logic [1:0]       synced, absent;
  logic [SEQ_W-1:0] seq;

  logic       one_abs, abs_idx, nxt_sel, rx_good;
  logic [1:0] my_addr;
  logic [3:0] nxt_cmd, rx_cmd;

  assign my_addr   = sel ? 2'b10 : 2'b01;
  assign tx_byte   = {1'b0, ~^{cmd_q, my_addr}, cmd_q, my_addr};
  assign tx_strobe = (st == S_SEND);
  assign slave_up  = synced;
  assign slave_absent = absent;

  assign rx_cmd  = rx_byte[5:2];
  assign rx_good = rx_valid && !rx_byte[7] && (^rx_byte[6:0]) && (rx_byte[1:0] == my_addr);

  assign one_abs = absent[0] ^ absent[1];
  assign abs_idx = absent[1];

  always_comb begin
    if (one_abs) nxt_sel = (skip == PW'(PROBE_GAP)) ? abs_idx : ~abs_idx;
    else         nxt_sel = ~last;
    if (!synced[nxt_sel])     nxt_cmd = C_LINKRST;
    else if (data_pend[nxt_sel]) nxt_cmd = C_BUFQ;
    else                      nxt_cmd = C_POLL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_PICK;
      sel      <= 1'b0;
      last     <= 1'b1;
      cmd_q    <= C_IDLE;
      tmr      <= '0;
      miss[0]  <= '0;
      miss[1]  <= '0;
      skip     <= '0;
      synced   <= '0;
      absent   <= '0;
      seq      <= '0;
      data_go  <= 1'b0;
      data_dst <= 1'b0;
      data_seq <= '0;
    end else begin
      data_go <= 1'b0;
      case (st)
        S_PICK: begin
          sel   <= nxt_sel;
          last  <= nxt_sel;
          cmd_q <= nxt_cmd;
          if (one_abs) skip <= (skip == PW'(PROBE_GAP)) ? '0 : skip + 1'b1;
          else         skip <= '0;
          st <= S_SEND;
        end
        S_SEND: begin
          tmr <= '0;
          st  <= S_WAIT;
        end
        default: begin
          if (rx_good) begin
            miss[sel]   <= '0;
            absent[sel] <= 1'b0;
            case (cmd_q)
              C_LINKRST: if (rx_cmd == C_IDLE) synced[sel] <= 1'b1;
              C_POLL:    if (rx_cmd == C_REBOOT) synced[sel] <= 1'b0;
              C_BUFQ:    if (rx_cmd == C_BUF_OK) begin
                data_go  <= 1'b1;
                data_dst <= sel;
                data_seq <= seq;
                seq      <= seq + 1'b1;
              end
              default: ;
            endcase
            st <= S_PICK;
          end else if (rx_valid || tmr == TW'(TIMEOUT - 1)) begin
            if (miss[sel] >= MW'(MISS_LIMIT - 1)) begin
              miss[sel]   <= MW'(MISS_LIMIT);
              absent[sel] <= 1'b1;
              synced[sel] <= 1'b0;
            end else begin
              miss[sel] <= miss[sel] + 1'b1;
            end
            st <= S_PICK;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module link_poll_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_strobe,
  input logic [7:0] tx_byte,
  input logic       rx_valid,
  input logic       data_go,
  input logic [1:0] slave_up,
  input logic [1:0] slave_absent
);
  p_byte_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> (!tx_byte[7] && (($countones(tx_byte[6:0]) & 1) == 1)));
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> !tx_strobe);
  p_go_after_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> $past(rx_valid));
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |=> !data_go);
  p_up_needs_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_up[0]) |-> $past(rx_valid));
  p_up_excl_absent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_up & slave_absent) == 2'b00);
endmodule

bind link_poll_master link_poll_master_chk chk_i (.*);

// File: tb/link_poll_master_tb_top.sv
module link_poll_master_tb_top;
  localparam int TMO = 16, MISSES = 3, GAP = 3, SW = 8;
  localparam logic [3:0] K_IDLE = 0, K_POLL = 1, K_REBOOT = 3, K_LINKRST = 4,
                         K_BUFQ = 5, K_BUF_NO = 6, K_BUF_OK = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] data_pend = 0;
  logic rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic tx_strobe, data_go, data_dst;
  logic [7:0] tx_byte;
  logic [SW-1:0] data_seq;
  logic [1:0] slave_up, slave_absent;

  always #10 clk = ~clk;

  link_poll_master #(.TIMEOUT(TMO), .MISS_LIMIT(MISSES), .PROBE_GAP(GAP), .SEQ_W(SW)) dut_i (.*);

  int vecs = 0, bad = 0;
  logic [1:0] present = 2'b11, buf_ok = 2'b11, reboot_req = 0, bf_reboot = 0;
  int corrupt_mode = 0;
  int strobe_cnt = 0, go_cnt = 0, bufq_a = 0, nores_b = 0, exp_seq = 0;
  logic [7:0] slog [$];
  int exp_q [$];

  function automatic logic [7:0] mk(input logic s, input logic [3:0] c);
    logic [6:0] low;
    low = {1'b0, c, s ? 2'b10 : 2'b01};
    low[6] = ($countones(low[5:0]) % 2 == 0);
    return {1'b0, low};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobes(input int n);
    int t = strobe_cnt;
    while (strobe_cnt < t + n) @(negedge clk);
  endtask

  // reactive slave model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_strobe) begin
        logic s;
        logic [3:0] c;
        logic [7:0] ans;
        bit send;
        strobe_cnt++;
        slog.push_back(tx_byte);
        chk(($countones(tx_byte[6:0]) % 2 == 1) && !tx_byte[7] &&
            (tx_byte[1:0] == 2'b01 || tx_byte[1:0] == 2'b10), "R1 byte form", tx_byte, 0);
        s = (tx_byte[1:0] == 2'b10);
        c = tx_byte[5:2];
        send = present[s];
        ans = mk(s, K_IDLE);
        if (!s && c == K_BUFQ) bufq_a++;
        if (s && !send) nores_b++;
        if (send) begin
          if (c == K_POLL && !s && corrupt_mode != 0) begin
            ans = mk(s, K_REBOOT);
            if (corrupt_mode == 1) ans[6] = ~ans[6];
            else ans[1:0] = 2'b10;
            corrupt_mode = 0;
          end else if (c == K_POLL && reboot_req[s]) begin
            ans = mk(s, K_REBOOT);
            reboot_req[s] = 0;
          end else if (c == K_BUFQ) begin
            if (bf_reboot[s]) begin
              ans = mk(s, K_REBOOT);
              bf_reboot[s] = 0;
            end else if (buf_ok[s]) begin
              ans = mk(s, K_BUF_OK);
              exp_q.push_back((int'(s) << 8) | exp_seq);
              exp_seq++;
            end else ans = mk(s, K_BUF_NO);
          end
          repeat (3) @(negedge clk);
          rx_byte = ans;
          rx_valid = 1;
          @(negedge clk);
          rx_valid = 0;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && data_go) begin
        int got, e;
        go_cnt++;
        got = (int'(data_dst) << 8) | int'(data_seq);
        if (exp_q.size() == 0) chk(0, "R5 unexpected grant", got, -1);
        else begin
          e = exp_q.pop_front();
          chk(got == e, "R5 grant dst/seq", got, e);
        end
      end
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic wait_a_strobe(output logic [7:0] b);
    int t;
    do begin
      t = strobe_cnt;
      while (strobe_cnt == t) @(negedge clk);
      b = slog[slog.size()-1];
    end while (b[1:0] != 2'b01);
  endtask

  initial begin
    int idx, go0, lastb, nb;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(slave_up == 0 && slave_absent == 0 && !tx_strobe && !data_go, "R2 reset state",
        {slave_up, slave_absent}, 0);
    rst_n = 1;
    wait_strobes(2);
    chk(slog[0] == mk(0, K_LINKRST), "R2 first LINKRST to A", slog[0], mk(0, K_LINKRST));
    chk(slog[1] == mk(1, K_LINKRST), "R2 LINKRST to B", slog[1], mk(1, K_LINKRST));
    wait_strobes(1);
    chk(slave_up == 2'b11, "R2 both synced after IDLE", slave_up, 3);

    // R3/R4 alternation and POLL
    idx = slog.size();
    wait_strobes(4);
    for (int i = 0; i < 4; i++)
      chk(slog[idx+i] == mk(((idx + i) % 2) == 1, K_POLL), "R3 R4 alternating POLL",
          slog[idx+i], mk(((idx + i) % 2) == 1, K_POLL));

    // R5 grants with sequence numbers
    go0 = go_cnt;
    data_pend[0] = 1;
    while (go_cnt == go0) @(negedge clk);
    data_pend[0] = 0;
    chk(bufq_a >= 1, "R4 BUFQ sent for pending A", bufq_a, 1);
    data_pend[1] = 1;
    while (go_cnt == go0 + 1) @(negedge clk);
    data_pend[1] = 0;
    chk(go_cnt == go0 + 2, "R5 two grants", go_cnt, go0 + 2);

    // R6 no buffer holds the data
    buf_ok[0] = 0;
    go0 = go_cnt;
    idx = bufq_a;
    data_pend[0] = 1;
    wait_strobes(6);
    chk(go_cnt == go0, "R6 no grant on BUF_NO", go_cnt, go0);
    chk(bufq_a >= idx + 2, "R6 BUFQ repeated", bufq_a - idx, 2);
    buf_ok[0] = 1;
    while (go_cnt == go0) @(negedge clk);
    data_pend[0] = 0;
    chk(go_cnt == go0 + 1, "R6 grant after space frees", go_cnt, go0 + 1);

    // R8 reboot in answer to BUFQ ignored
    bf_reboot[0] = 1;
    data_pend[0] = 1;
    while (bf_reboot[0]) @(negedge clk);
    data_pend[0] = 0;
    repeat (8) @(negedge clk);
    chk(slave_up[0] == 1, "R8 reboot to BUFQ ignored", slave_up[0], 1);
    wait_a_strobe(b);
    chk(b[5:2] != K_LINKRST, "R8 no LINKRST after ignored reboot", b[5:2], K_POLL);
    go0 = go_cnt;
    while (go_cnt == go0 && exp_q.size() != 0) @(negedge clk);

    // R7 reboot in answer to POLL
    reboot_req[0] = 1;
    while (reboot_req[0]) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(slave_up[0] == 0, "R7 slave_up cleared on reboot", slave_up[0], 0);
    wait_a_strobe(b);
    chk(b == mk(0, K_LINKRST), "R7 LINKRST after reboot", b, mk(0, K_LINKRST));
    repeat (6) @(negedge clk);
    chk(slave_up[0] == 1, "R2 R7 resynced", slave_up[0], 1);

    // R9 corrupted answers ignored
    for (int m = 1; m <= 2; m++) begin
      corrupt_mode = m;
      while (corrupt_mode != 0) @(negedge clk);
      wait_a_strobe(b);
      chk(b == mk(0, K_POLL) && slave_up[0] && !slave_absent[0], "R9 corrupt answer is a miss",
          b, mk(0, K_POLL));
    end

    // R10 absence detection
    present[1] = 0;
    nores_b = 0;
    while (!slave_absent[1]) @(negedge clk);
    chk(nores_b == MISSES, "R10 absent after MISS_LIMIT misses", nores_b, MISSES);
    chk(slave_up[1] == 0, "R10 slave_up cleared", slave_up[1], 0);
    chk(slave_absent[0] == 0, "R10 A stays present", slave_absent[0], 0);

    // R11 probe spacing
    idx = slog.size();
    wait_strobes(14);
    lastb = -1;
    nb = 0;
    for (int i = idx; i < idx + 14; i++) begin
      if (slog[i][1:0] == 2'b10) begin
        chk(slog[i][5:2] == K_LINKRST, "R11 probe is LINKRST", slog[i][5:2], K_LINKRST);
        if (lastb >= 0) chk(i - lastb - 1 == GAP, "R11 probe gap", i - lastb - 1, GAP);
        lastb = i;
        nb++;
      end
    end
    chk(nb >= 2, "R11 probes seen", nb, 3);

    // R12 recovery
    present[1] = 1;
    wait_strobes(GAP + 3);
    chk(slave_absent[1] == 0 && slave_up[1] == 1, "R12 recovered", {slave_absent[1], slave_up[1]}, 1);
    idx = slog.size();
    wait_strobes(2);
    chk(slog[idx][1:0] != slog[idx+1][1:0], "R3 alternation resumes", slog[idx+1], slog[idx]);

    chk(exp_q.size() == 0, "R5 all grants seen", exp_q.size(), 0);
    finish_run();
  end
endmodule